// File: doc/BRIEF.md
# Dual-Counter Performance Monitor

This block counts core events for profiling. Two 32-bit counters sit side by side in one 64-bit counter word, and a single 64-bit control word sets what they count. Each counter has its own event-select field, which picks one line out of a vector of single-cycle event pulses from the core. Counting is gated by three enable bits, one for each privilege mode (user, supervisor, hypervisor). These bits are shared by both counters, so neither counter can be stopped on its own.

To keep a counter quiet while the other one runs, software points its select field at a reserved parking code. That code never produces a count. When a counter rolls over from all ones to zero, a sticky overflow flag in the control word is set, and an interrupt is raised if the interrupt enable is set. Software can preload a counter with the two's complement of N so that it overflows after exactly N events.

A compile-time parameter picks one of two control-word layouts: a narrow one with 6-bit select fields and a wide one with 12-bit select fields. Register access is a plain write strobe with an address bit, plus a combinational read port.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, the counter word, the control word and both overflow flags read zero, and `irq_o` is low.
- R2: Address 1 is the counter word: bits 63:32 hold the upper counter and bits 31:0 hold the lower counter, and both are written and read as one 64-bit value. Address 0 is the control word.
- R3: A counter goes up by exactly one on a clock edge when its selected event line is high and the enable bit for `priv_i` is set. `priv_i` is coded 0 = user, 1 = supervisor, 2 = hypervisor, 3 = no mode; code 3 never counts.
- R4: While the user, supervisor and hypervisor enable bits are all clear, neither counter changes except by a register write.
- R5: Narrow layout (WIDE=0): upper select is bits 16:11, lower select is bits 9:4, interrupt enable is bit 0, supervisor enable is bit 1, user enable is bit 2, hypervisor enable is bit 3. The lower overflow flag is bit 40 and the upper overflow flag is bit 41.
- R6: Wide layout (WIDE=1): upper select is bits 30:19, lower select is bits 17:6, interrupt enable is bits 1:0 (either bit enables), user enable is bit 2, hypervisor enable is bit 3, supervisor enable is bit 4. The flags stay at bits 40 and 41.
- R7: A counted step from 0xFFFFFFFF to 0 sets that counter's sticky overflow flag. `irq_o` is high exactly when a flag is set and the interrupt enable is set.
- R8: Writing 0 to a flag bit of the control word clears the flag. If a rollover happens in the same cycle, the set takes priority.
- R9: A counter preloaded with the two's complement of N overflows on the Nth counted event and not earlier.
- R10: A select field that holds the parking code never counts, whatever the event lines do. The parking code is 0x1C for the upper counter and 0x14 for the lower counter in the narrow layout, and 0x220 for both in the wide layout.
- R11: A select value at or above NUM_EVT never counts.
- R12: If a counter-word write and an increment land in the same cycle, the written value is kept and the increment is lost.
- R13: Control-word bits outside the defined fields read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_i | input | NUM_EVT | Single-cycle event pulses from the core |
| priv_i | input | 2 | Current privilege mode (0 user, 1 supervisor, 2 hypervisor, 3 none) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write target: 0 control word, 1 counter word |
| wr_data_i | input | 64 | Write data |
| rd_addr_i | input | 1 | Read select: 0 control word, 1 counter word |
| rd_data_o | output | 64 | Read data (combinational) |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench builds two copies with NUM_EVT=32 that share the same stimulus: `dut_i` uses the narrow layout and a second copy uses the wide layout. With 32 event lines, a 6-bit select field can name lines that do not exist, so the out-of-range rule can be tested, and both narrow parking codes fall on real event lines that the bench drives high. Running the wide copy alongside the narrow one checks its own field positions, its relocated supervisor bit and its two-bit interrupt enable.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CNT_W = 32;
  localparam int REG_W = 64;
  localparam int OVF_LO_BIT = 40;
  localparam int OVF_HI_BIT = 41;

  typedef enum logic [1:0] {
    PRIV_USER = 2'd0,
    PRIV_SUP  = 2'd1,
    PRIV_HYP  = 2'd2,
    PRIV_NONE = 2'd3
  } priv_e;

  function automatic int sel_width(input bit wide);
    return wide ? 12 : 6;
  endfunction

  function automatic int hi_lsb(input bit wide);
    return wide ? 19 : 11;
  endfunction

  function automatic int lo_lsb(input bit wide);
    return wide ? 6 : 4;
  endfunction

  function automatic int usr_bit(input bit wide);
    return wide ? 2 : 2;
  endfunction

  function automatic int sup_bit(input bit wide);
    return wide ? 4 : 1;
  endfunction

  function automatic int hyp_bit(input bit wide);
    return wide ? 3 : 3;
  endfunction

  function automatic int irq_msb(input bit wide);
    return wide ? 1 : 0;
  endfunction

  function automatic int park_hi(input bit wide);
    return wide ? 'h220 : 'h1C;
  endfunction

  function automatic int park_lo(input bit wide);
    return wide ? 'h220 : 'h14;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_mask(input bit wide);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i <= irq_msb(wide); i++) m[i] = 1'b1;
    m[usr_bit(wide)] = 1'b1;
    m[sup_bit(wide)] = 1'b1;
    m[hyp_bit(wide)] = 1'b1;
    for (int i = 0; i < sel_width(wide); i++) begin
      m[hi_lsb(wide) + i] = 1'b1;
      m[lo_lsb(wide) + i] = 1'b1;
    end
    m[OVF_LO_BIT] = 1'b1;
    m[OVF_HI_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pmu_evt_gate.sv
module pmu_evt_gate #(
  parameter int SEL_W   = 6,
  parameter int NUM_EVT = 32,
  parameter int PARK    = 'h1C
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               hit_o
);
  localparam logic [SEL_W-1:0] PARK_CODE = SEL_W'(PARK);

  logic line;

  always_comb begin
    line = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if ({{(32-SEL_W){1'b0}}, sel_i} == 32'(i)) line = evt_i[i];
    end
  end

  assign hit_o = line & (sel_i != PARK_CODE);
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_n;
  logic         cnt_en;

  always_comb begin
    cnt_n  = cnt_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_n  = load_val_i;
      cnt_en = 1'b1;
    end else if (inc_i) begin
      cnt_n  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i & ~load_i & (&cnt_q);
endmodule

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
  import pmu_pkg::*;
#(
  parameter bit WIDE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [1:0]       wrap_i,
  output logic [REG_W-1:0] ctrl_o
);
  localparam logic [REG_W-1:0] MASK = ctrl_mask(WIDE);

  logic [REG_W-1:0] ctrl_q, ctrl_n;
  logic             ctrl_en;

  always_comb begin
    ctrl_n = wr_i ? (wr_data_i & MASK) : ctrl_q;
    if (wrap_i[0]) ctrl_n[OVF_LO_BIT] = 1'b1;
    if (wrap_i[1]) ctrl_n[OVF_HI_BIT] = 1'b1;
    ctrl_en = wr_i | (|wrap_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_n;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter bit WIDE    = 1'b0,
  parameter int NUM_EVT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [1:0]         priv_i,
  input  logic               wr_en_i,
  input  logic               wr_addr_i,
  input  logic [63:0]        wr_data_i,
  input  logic               rd_addr_i,
  output logic [63:0]        rd_data_o,
  output logic               irq_o
);
  localparam int SEL_W = sel_width(WIDE);
  localparam int HI_LO = hi_lsb(WIDE);
  localparam int LO_LO = lo_lsb(WIDE);
  localparam int USR   = usr_bit(WIDE);
  localparam int SUP   = sup_bit(WIDE);
  localparam int HYP   = hyp_bit(WIDE);
  localparam int IRQ_H = irq_msb(WIDE);

  logic [1:0]       rst_pipe;
  logic             rst_q;
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] cnt_pk;
  logic [1:0]       hit, wrap;
  logic             mode_en, wr_ctrl, wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  assign wr_ctrl = wr_en_i & ~wr_addr_i;
  assign wr_cnt  = wr_en_i &  wr_addr_i;

  always_comb begin
    unique case (priv_e'(priv_i))
      PRIV_USER: mode_en = ctrl_q[USR];
      PRIV_SUP:  mode_en = ctrl_q[SUP];
      PRIV_HYP:  mode_en = ctrl_q[HYP];
      default:   mode_en = 1'b0;
    endcase
  end

  for (genvar g = 0; g < 2; g++) begin : g_slot
    localparam int LSB  = (g == 1) ? HI_LO : LO_LO;
    localparam int PARK = (g == 1) ? park_hi(WIDE) : park_lo(WIDE);

    pmu_evt_gate #(.SEL_W(SEL_W), .NUM_EVT(NUM_EVT), .PARK(PARK)) u_gate (
      .sel_i (ctrl_q[LSB +: SEL_W]),
      .evt_i (evt_i),
      .hit_o (hit[g])
    );

    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_q),
      .load_i     (wr_cnt),
      .load_val_i (wr_data_i[g*CNT_W +: CNT_W]),
      .inc_i      (hit[g] & mode_en),
      .cnt_o      (cnt_pk[g*CNT_W +: CNT_W]),
      .wrap_o     (wrap[g])
    );
  end

  pmu_ctrl_reg #(.WIDE(WIDE)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_q),
    .wr_i      (wr_ctrl),
    .wr_data_i (wr_data_i),
    .wrap_i    (wrap),
    .ctrl_o    (ctrl_q)
  );

  assign irq_o     = (|ctrl_q[IRQ_H:0]) & (ctrl_q[OVF_LO_BIT] | ctrl_q[OVF_HI_BIT]);
  assign rd_data_o = rd_addr_i ? cnt_pk : ctrl_q;
endmodule

// File: rtl/pmu_chk.sv
module pmu_chk
  import pmu_pkg::*;
#(
  parameter bit WIDE = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] ctrl_q,
  input logic [63:0] cnt_pk,
  input logic        wr_en_i,
  input logic        wr_addr_i,
  input logic [63:0] wr_data_i,
  input logic        irq_o
);
  localparam int SEL_W = sel_width(WIDE);
  logic        wr_cnt;
  logic [31:0] c_lo, c_hi;
  logic        any_en;

  assign wr_cnt = wr_en_i & wr_addr_i;
  assign c_lo   = cnt_pk[31:0];
  assign c_hi   = cnt_pk[63:32];
  assign any_en = ctrl_q[usr_bit(WIDE)] | ctrl_q[sup_bit(WIDE)] | ctrl_q[hyp_bit(WIDE)];

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> (c_lo == $past(c_lo) || c_lo == $past(c_lo) + 32'd1));

  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && !any_en) |=> ($stable(c_lo) && $stable(c_hi)));

  assert_wrap_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_lo == 32'd0 && $past(c_lo) == 32'hFFFF_FFFF && !$past(wr_cnt)) |-> ctrl_q[OVF_LO_BIT]);

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ctrl_q[OVF_LO_BIT] | ctrl_q[OVF_HI_BIT]));

  assert_park_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && ctrl_q[hi_lsb(WIDE) +: SEL_W] == SEL_W'(park_hi(WIDE))) |=> $stable(c_hi));

  assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_pk == $past(wr_data_i)));
endmodule

bind perf_mon_unit pmu_chk #(.WIDE(WIDE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .ctrl_q    (ctrl_q),
  .cnt_pk    (cnt_pk),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .irq_o     (irq_o)
);

// File: tb/perf_mon_unit_tb_top.sv
`timescale 1ns/1ps
module perf_mon_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt = '0;
  logic [1:0]  priv = 2'd3;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [63:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [63:0] rd_n, rd_w;
  logic        irq_n, irq_w;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  perf_mon_unit #(.WIDE(1'b0), .NUM_EVT(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .priv_i(priv), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_n), .irq_o(irq_n));

  perf_mon_unit #(.WIDE(1'b1), .NUM_EVT(32)) dut_w (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .priv_i(priv), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_w), .irq_o(irq_w));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [63:0] vn, output logic [63:0] vw);
    rd_addr = a;
    #0.5;
    vn = rd_n; vw = rd_w;
  endtask

  task automatic pulse(input logic [31:0] m, input int n);
    evt = m;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  function automatic logic [63:0] nctl(input int hs, input int ls, input logic [3:0] lo4);
    return (64'(hs) << 11) | (64'(ls) << 4) | 64'(lo4);
  endfunction

  task automatic t_reset();
    logic [63:0] a, b;
    rd(1'b0, a, b); chk("R1 ctrl", a, 64'h0);
    rd(1'b1, a, b); chk("R1 counters", a, 64'h0);
    chk("R1 irq", {63'h0, irq_n}, 64'h0);
  endtask

  task automatic t_pack();
    logic [63:0] a, b;
    wr(1'b1, 64'h1111_2222_3333_4444);
    rd(1'b1, a, b); chk("R2 packed word", a, 64'h1111_2222_3333_4444);
  endtask

  task automatic t_count();
    logic [63:0] a, b;
    wr(1'b1, 64'h0);
    wr(1'b0, nctl(5, 7, 4'b0100));   // user only, R5 field layout
    priv = 2'd0;
    pulse(32'h0000_0020, 3);          // line 5
    pulse(32'h0000_00A0, 1);          // lines 5 and 7
    rd(1'b1, a, b); chk("R3 R5 user count", a, {32'd4, 32'd1});
    priv = 2'd1; pulse(32'h0000_00A0, 2);
    priv = 2'd3; pulse(32'h0000_00A0, 2);
    rd(1'b1, a, b); chk("R3 disabled modes", a, {32'd4, 32'd1});
    wr(1'b0, nctl(5, 7, 4'b1000));    // hypervisor only
    priv = 2'd2; pulse(32'h0000_0080, 2);
    rd(1'b1, a, b); chk("R3 hyp count", a, {32'd4, 32'd3});
    wr(1'b0, nctl(5, 7, 4'b0010));    // supervisor only
    priv = 2'd1; pulse(32'h0000_0020, 1);
    rd(1'b1, a, b); chk("R5 sup bit", a, {32'd5, 32'd3});
  endtask

  task automatic t_freeze();
    logic [63:0] a, b;
    wr(1'b0, nctl(5, 7, 4'b0000));
    for (int p = 0; p < 4; p++) begin
      priv = 2'(p);
      pulse(32'hFFFF_FFFF, 2);
    end
    rd(1'b1, a, b); chk("R4 frozen", a, {32'd5, 32'd3});
  endtask

  task automatic t_overflow();
    logic [63:0] a, b;
    wr(1'b1, {32'h0, 32'hFFFF_FFFD});
    wr(1'b0, nctl(9, 7, 4'b0101));
    priv = 2'd0;
    pulse(32'h0000_0080, 2);
    rd(1'b0, a, b); chk("R9 no early flag", a[40], 1'b0);
    chk("R9 no early irq", {63'h0, irq_n}, 64'h0);
    pulse(32'h0000_0080, 1);
    rd(1'b1, a, b); chk("R7 wrapped to zero", a, 64'h0);
    rd(1'b0, a, b); chk("R7 lo flag", {a[41], a[40]}, 64'h1);
    chk("R7 irq raised", {63'h0, irq_n}, 64'h1);
    wr(1'b0, nctl(9, 7, 4'b0100) | (64'h1 << 40));
    chk("R7 irq masked", {63'h0, irq_n}, 64'h0);
    wr(1'b0, nctl(9, 7, 4'b0101));
    rd(1'b0, a, b); chk("R8 flag cleared", a[40], 1'b0);
    chk("R8 irq low", {63'h0, irq_n}, 64'h0);
    // R8: rollover in the same cycle as a clearing write keeps the flag
    wr(1'b1, {32'h0, 32'hFFFF_FFFF});
    evt = 32'h0000_0080;
    wr(1'b0, nctl(9, 7, 4'b0101));
    evt = '0;
    rd(1'b0, a, b); chk("R8 set beats clear", a[40], 1'b1);
    wr(1'b0, nctl(9, 7, 4'b0101));
  endtask

  task automatic t_park();
    logic [63:0] a, b;
    wr(1'b1, 64'h0);
    wr(1'b0, nctl('h1C, 'h14, 4'b0100));
    priv = 2'd0;
    pulse(32'hFFFF_FFFF, 3);
    rd(1'b1, a, b); chk("R10 parked", a, 64'h0);
  endtask

  task automatic t_range();
    logic [63:0] a, b;
    wr(1'b1, 64'h0);
    wr(1'b0, nctl(5, 40, 4'b0100));
    priv = 2'd0;
    pulse(32'hFFFF_FFFF, 2);
    rd(1'b1, a, b); chk("R11 out of range", a, {32'd2, 32'd0});
  endtask

  task automatic t_collide();
    logic [63:0] a, b;
    wr(1'b0, nctl(5, 7, 4'b0100));
    priv = 2'd0;
    evt = 32'h0000_00A0;
    wr(1'b1, 64'h0000_0010_0000_0020);
    evt = '0;
    rd(1'b1, a, b); chk("R12 write wins", a, 64'h0000_0010_0000_0020);
  endtask

  task automatic t_unused();
    logic [63:0] a, b;
    wr(1'b0, '1);
    rd(1'b0, a, b); chk("R13 narrow mask", a, 64'h0000_0300_0001_FBFF);
    chk("R13 wide mask", b, 64'h0000_0300_7FFB_FFDF);
  endtask

  task automatic t_wide();
    logic [63:0] a, b;
    chk("R6 wide irq", {63'h0, irq_w}, 64'h1);
    wr(1'b0, (64'h1 << 41) | 64'h2);
    chk("R6 irq bit1", {63'h0, irq_w}, 64'h1);
    wr(1'b1, 64'h0);
    wr(1'b0, (64'd3 << 19) | (64'd9 << 6) | 64'h8);
    priv = 2'd2;
    pulse(32'h0000_0208, 1);
    rd(1'b1, a, b); chk("R6 wide hyp count", b, {32'd1, 32'd1});
    wr(1'b0, (64'd3 << 19) | (64'd9 << 6) | 64'h10);
    priv = 2'd1;
    pulse(32'h0000_0208, 1);
    rd(1'b1, a, b); chk("R6 wide sup bit", b, {32'd2, 32'd2});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pack();
    t_count();
    t_freeze();
    t_overflow();
    t_park();
    t_range();
    t_collide();
    t_unused();
    t_wide();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule